// File: doc/BRIEF.md
# Snapshot-Read 64-bit Tick Counter

This block keeps a free-running count of input ticks and makes it readable over a 32-bit register bus. The count is wider than one bus word, and reading it as two separate words could tear. To avoid that, software first writes a capture request to the control word. The block then copies the whole count into a holding register. Software polls the request bit until it reads 0, and then reads the low and high words at separate offsets. Both words always come from the same capture instant.

The counter starts at zero out of reset and advances once for each clock cycle in which `tick_i` is high. Software cannot write the count. The bus is a plain single-cycle register port:

- A write is taken in the cycle where `bus_wr_i` is high.
- Read data is a combinational function of `bus_addr_i` and has no side effect.
- There is no back-pressure: every write completes in its own cycle.
- A capture request that arrives while a capture is still in progress is dropped, not queued.

Top module: `latched_counter`

## Requirements
- R1: After reset, the count and the holding register are zero, so the control word (offset 0xA0), low word (0xA4) and high word (0xA8) all read 0.
- R2: The count increases by exactly one at each clock edge where `tick_i` is high and is unchanged otherwise; the difference between two snapshots equals the number of ticks between their request cycles.
- R3: A bus write to offset 0xA0 with data bit 1 set, while no capture is pending, makes control bit 1 read 1 for exactly LAT (default 2) cycles after the write edge and then 0; all other control bits read 0.
- R4: Once control bit 1 has dropped, offset 0xA4 returns bits 31:0 and offset 0xA8 returns bits 63:32 of the count value present in the request write cycle.
- R5: The holding register does not change through any number of reads or ticks until a later request completes.
- R6: A write to offset 0xA0 with data bit 1 clear starts nothing: control bit 1 stays 0 and the snapshot words are unchanged.
- R7: A request written while a capture is pending is ignored: control bit 1 still clears LAT cycles after the first request, and the snapshot is that of the first request.
- R8: The count wraps modulo 2^CNT_W back to zero; when CNT_W is below 64, the unused upper bits of the snapshot read 0.
- R9: Any offset other than 0xA0, 0xA4 or 0xA8 reads 0, and a write to any other offset starts no capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-advance strobe, one increment per high cycle |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 8 | Register byte offset |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Register read data for the current offset |

## Verification
The bound assertions cover the cycle-level rules on every cycle:
- the count steps by one only on a tick;
- an accepted request raises the pending flag;
- the flag stays up for exactly LAT cycles, even under repeated requests;
- the holding register changes only on the cycle the flag drops;
- unmapped offsets read zero.

Whether the captured words match the count from the request cycle is shown only by the bench scenarios, which compare against an independent tick model. The same holds for the word split, for the rejection of writes with the bit clear, and for the wrap seen on a narrow instance.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] OFF_CTRL = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_LO   = 8'hA4;
  localparam logic [ADDR_W-1:0] OFF_HI   = 8'hA8;
  localparam int REQ_BIT = 1;
endpackage

// File: rtl/lc_tick_counter.sv
module lc_tick_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  output logic [CNT_W-1:0] count_o
);
  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      count_q <= '0;
    else if (tick_i) count_q <= count_q + 1'b1;
  end

  assign count_o = count_q;
endmodule

// File: rtl/lc_snap_ctrl.sv
module lc_snap_ctrl #(
  parameter int CNT_W = 64,
  parameter int LAT   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             busy_o,
  output logic [CNT_W-1:0] hold_o
);
  localparam int RW = $clog2(LAT + 1);

  logic [RW-1:0]    remain_q;
  logic [CNT_W-1:0] stage_q;
  logic [CNT_W-1:0] hold_q;
  logic             idle;

  assign idle = (remain_q == '0);

  // Capture into a stage at the request edge; publish after LAT cycles.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      stage_q  <= '0;
      hold_q   <= '0;
    end else if (req_i && idle) begin
      stage_q  <= count_i;
      remain_q <= RW'(LAT);
    end else if (!idle) begin
      remain_q <= remain_q - 1'b1;
      if (remain_q == RW'(1)) hold_q <= stage_q;
    end
  end

  assign busy_o = !idle;
  assign hold_o = hold_q;
endmodule

// File: rtl/lc_regs.sv
module lc_regs
  import lc_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              busy_i,
  input  logic [CNT_W-1:0]  hold_i,
  output logic              req_o,
  output logic [BUS_W-1:0]  rdata_o
);
  localparam int WIDE = 2 * BUS_W;
  localparam int PAD  = WIDE - CNT_W;

  logic [WIDE-1:0] wide;
  logic            unused_wdata;

  generate
    if (PAD == 0) begin : g_full
      assign wide = hold_i;
    end else begin : g_pad
      assign wide = {{PAD{1'b0}}, hold_i};
    end
  endgenerate

  assign unused_wdata = ^wdata_i;
  assign req_o = wr_i && (addr_i == OFF_CTRL) && wdata_i[REQ_BIT];

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      OFF_CTRL: rdata_o[REQ_BIT] = busy_i;
      OFF_LO:   rdata_o = wide[BUS_W-1:0];
      OFF_HI:   rdata_o = wide[WIDE-1:BUS_W];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/latched_counter.sv
module latched_counter
  import lc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  output logic [BUS_W-1:0]  bus_rdata_o
);
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] hold_w;
  logic             busy_w;
  logic             req_w;

  lc_tick_counter #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .count_o(count_w)
  );

  lc_snap_ctrl #(.CNT_W(CNT_W), .LAT(LAT)) u_snap (
    .clk(clk), .rst_n(rst_n), .req_i(req_w), .count_i(count_w),
    .busy_o(busy_w), .hold_o(hold_w)
  );

  lc_regs #(.CNT_W(CNT_W)) u_regs (
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .busy_i(busy_w), .hold_i(hold_w), .req_o(req_w), .rdata_o(bus_rdata_o)
  );
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
#(
  parameter int CNT_W = 64,
  parameter int LAT   = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_i,
  input logic              req,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  hold,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  rdata
);
  localparam int RUN_W = $clog2(LAT + 2);
  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  assert_tick_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
  assert_no_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(cnt));
  assert_req_raises_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !busy) |=> busy);
  assert_busy_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < RUN_W'(LAT)));
  assert_busy_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == RUN_W'(LAT)));
  assert_hold_only_on_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(hold) |-> $fell(busy));
  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr != OFF_CTRL && addr != OFF_LO && addr != OFF_HI) |-> (rdata == '0));
endmodule

bind latched_counter lc_checker #(.CNT_W(CNT_W), .LAT(LAT)) u_lc_checker (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .req(req_w), .busy(busy_w),
  .cnt(count_w), .hold(hold_w), .addr(bus_addr_i), .rdata(bus_rdata_o)
);

// File: tb/latched_counter_bench.sv
`timescale 1ns/10ps
module latched_counter_bench;
  localparam logic [7:0] A_CTRL = 8'hA0;
  localparam logic [7:0] A_LO   = 8'hA4;
  localparam logic [7:0] A_HI   = 8'hA8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        n_wr = 1'b0;
  logic [7:0]  n_addr = 8'h00;
  logic [31:0] n_wdata = '0;
  logic [31:0] n_rdata;

  int          vectors = 0;
  int          fails = 0;
  int          tick_mode = 0;
  bit          finished = 1'b0;
  logic [63:0] m_cnt;
  logic [5:0]  n_cnt;

  always #2 clk = ~clk;

  latched_counter u_latched_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .bus_wr_i(bus_wr),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata)
  );

  latched_counter #(.CNT_W(6), .LAT(2)) u_narrow (
    .clk(clk), .rst_n(rst_n), .tick_i(1'b1), .bus_wr_i(n_wr),
    .bus_addr_i(n_addr), .bus_wdata_i(n_wdata), .bus_rdata_o(n_rdata)
  );

  // Independent tick models
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0;
      n_cnt <= '0;
    end else begin
      if (tick) m_cnt <= m_cnt + 64'd1;
      n_cnt <= n_cnt + 6'd1;
    end
  end

  always @(negedge clk) begin
    case (tick_mode)
      0:       tick <= 1'($urandom_range(0, 1));
      1:       tick <= 1'b0;
      default: tick <= 1'b1;
    endcase
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.3;
    d = bus_rdata;
  endtask

  task automatic read_snap(output logic [63:0] v);
    logic [31:0] lo, hi;
    rd(A_LO, lo);
    rd(A_HI, hi);
    v = {hi, lo};
  endtask

  // Request, check flag timing (R3), return the expected snapshot
  task automatic request(input logic [31:0] extra, input bit second, output logic [63:0] exp);
    logic [31:0] d;
    @(negedge clk);
    bus_addr = A_CTRL; bus_wdata = extra | 32'h2; bus_wr = 1'b1;
    exp = m_cnt;
    @(negedge clk);
    if (!second) bus_wr = 1'b0;   // R7: when second is set the write repeats while pending
    rd(A_CTRL, d); chk("R3", d, 32'h2);
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_CTRL, d); chk("R3", d, 32'h2);
    @(negedge clk);
    rd(A_CTRL, d); chk("R3", d, 32'h0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [63:0] e, v, prev, e2;
    void'($urandom(32'h5EED1234));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    rd(A_CTRL, d); chk("R1", d, 32'h0);
    rd(A_LO, d);   chk("R1", d, 32'h0);
    rd(A_HI, d);   chk("R1", d, 32'h0);

    // R3/R4: random ticks, random extra data bits
    for (int i = 0; i < 20; i++) begin
      repeat ($urandom_range(0, 7)) @(negedge clk);
      request($urandom, 1'b0, e);
      read_snap(v); chk("R4", v, e);
    end

    // R2: ticks frozen, then forced every cycle
    tick_mode = 1;
    repeat (2) @(negedge clk);
    request(32'h0, 1'b0, prev);
    read_snap(v); chk("R2", v, prev);
    request(32'h0, 1'b0, e);
    read_snap(v); chk("R2", v - prev, 64'd0);
    tick_mode = 2;
    repeat (10) @(negedge clk);
    request(32'h0, 1'b0, e);
    read_snap(v); chk("R2", v - prev, e - prev);
    chk("R2", (v > prev) ? 64'd1 : 64'd0, 64'd1);

    // R5: holding register stable through reads and ticks
    tick_mode = 0;
    request(32'h0, 1'b0, e);
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      read_snap(v); chk("R5", v, e);
    end

    // R6: write with request bit clear
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      bus_addr = A_CTRL; bus_wdata = $urandom & ~32'h2; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      rd(A_CTRL, d); chk("R6", d, 32'h0);
      repeat (3) @(negedge clk);
      read_snap(v); chk("R6", v, e);
    end

    // R7: second request while pending
    request(32'h0, 1'b1, e2);
    read_snap(v); chk("R7", v, e2);
    repeat (3) @(negedge clk);
    read_snap(v); chk("R7", v, e2);

    // R9: unmapped offsets and writes elsewhere
    for (int i = 0; i < 12; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if (a == A_CTRL || a == A_LO || a == A_HI) a = 8'h10;
      @(negedge clk);
      bus_addr = a; bus_wdata = 32'hFFFF_FFFF; bus_wr = 1'b1;
      #0.3; chk("R9", bus_rdata, 32'h0);
      @(negedge clk);
      bus_wr = 1'b0;
      rd(A_CTRL, d); chk("R9", d, 32'h0);
    end
    read_snap(v); chk("R9", v, e2);

    // R8: narrow instance wraps at 2^6
    repeat (40) @(negedge clk);
    @(negedge clk);
    n_addr = A_CTRL; n_wdata = 32'h2; n_wr = 1'b1;
    e = {58'd0, n_cnt};
    @(negedge clk);
    n_wr = 1'b0;
    repeat (3) @(negedge clk);
    n_addr = A_LO; #0.3; chk("R8", n_rdata, e[31:0]);
    n_addr = A_HI; #0.3; chk("R8", n_rdata, 32'h0);

    finish_run();
  end
endmodule